// File: doc/BRIEF.md
# Write-Protected Clock Register Sequencer

This block sits between a simple register request port and a byte-level master for a three-wire serial clock/calendar device. Each register request becomes a fixed series of framed bus operations. A write is always wrapped by two control-register writes: the first lifts the device's write protection and the second puts it back. A read is a single frame: a command byte, then one byte clocked in.

When reset is released, the block checks by itself that the device is there. It lifts protection, stores a known byte in scratch RAM, restarts the frame and reads that byte back. If the device answers, the block restores protection and programs the trickle-charge register from a build-time setting. It then reads the seconds register and writes it back with the halt flag cleared, so the clock starts running. The probe result is kept as a sticky presence flag, and register requests are refused while that flag is low.

The byte port carries one operation at a time: open or restart a frame, send a byte, receive a byte, or close the frame. Each operation is held until the bus master acknowledges it.

Top module: `rtc_wp_seq`

## Requirements
- R1: A read request for index i issues exactly: frame open, send byte 0x81 | (i << 1), receive one byte, frame close. It then returns that received byte on `resp_rdata` with `resp_done` high and `resp_err` low.
- R2: A write request for index i with data d issues exactly twelve operations, in this order:
  - open, send 0x8E, send 0x00, close;
  - open, send 0x80 | (i << 1), send d, close;
  - open, send 0x8E, send 0x80, close.
- R3: With `READ_ONLY` set, a write request to any index other than `TRICKLE_IDX` (default 8) produces no bus operation and completes with `resp_err` high. A write to `TRICKLE_IDX` is carried out as in R2.
- R4: After reset the block probes the device:
  - It issues, in this order: open, 0x8E, 0x00, close, open, 0xC0, 0x42, open, 0xC1, receive, close.
  - If the received byte is 0x42, it issues open, 0x8E, 0x80, close, and `dev_present` goes high and stays high.
- R5: If the probe reads back any value other than 0x42, no further operation is issued after the probe's close. `dev_present` stays low and `busy` falls.
- R6: After a successful probe, the block writes `TRICKLE_TAG` (upper nibble, default 0xA0) ORed with `CHARGE[3:0]` to index `TRICKLE_IDX`, using the R2 sequence.
- R7: After the trickle write, the block reads index `SEC_IDX` (default 0) and writes the value back with bit 7 cleared, using the R1 and R2 sequences. Initialisation therefore issues 43 operations in total.
- R8: `busy` is high from reset until initialisation ends, and from the acceptance of a request until its response. A request presented while `busy` is high is ignored.
- R9: While `dev_present` is low, every request completes with `resp_err` high and no bus operation.
- R10: Byte-port operation codes are 0 = open/restart, 1 = send, 2 = receive, 3 = close. `txn_valid`, `txn_op` and `txn_byte` are held stable until `txn_ack`, and operations occur only while `busy` is high.
- R11: `resp_done` is a single-cycle pulse, never high while `busy` is high, and `resp_err` is high only together with `resp_done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the probe |
| req_valid | input | 1 | Request strobe, taken when `busy` is low |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_idx | input | IDX_W | Register index |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Sequence in progress |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_err | output | 1 | Request refused (absent device or read-only) |
| resp_rdata | output | 8 | Data from a completed read |
| dev_present | output | 1 | Sticky probe result |
| txn_valid | output | 1 | Byte operation pending |
| txn_op | output | 2 | Operation code (see R10) |
| txn_byte | output | 8 | Byte to send |
| txn_ack | input | 1 | Operation accepted and finished by the bus master |
| txn_rdata | input | 8 | Received byte, valid with `txn_ack` on a receive |

## Verification
The hardest path to reach from the ports is a failed probe. That path needs a device that accepts writes but returns a wrong scratch byte. It also depends on the block never restoring write protection afterwards, which can only be seen as operations that fail to appear. The bench therefore places a second and a third copy of the block on the same clock. Each has its own behavioural device model: one model answers reads with 0xFF, and one copy of the block is built in read-only mode. The bench logs every byte operation from each model, so that the absence of write-protect restoration, or of a discarded write, shows up as an operation count. The busy-time request that must be ignored is injected two cycles into a running read.

// File: rtl/rtc_seq_pkg.sv
package rtc_seq_pkg;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2,
    OP_STOP  = 2'd3
  } bus_op_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PROBE,
    PH_PROBE_WP,
    PH_RD,
    PH_WR
  } phase_e;

  typedef enum logic [1:0] {
    IN_NONE,
    IN_TRICKLE,
    IN_SEC_RD,
    IN_SEC_WR
  } init_e;

  localparam int STEP_W = 4;

  localparam logic [7:0] CTRL_WR_CMD = 8'h8E;
  localparam logic [7:0] WP_CLEAR    = 8'h00;
  localparam logic [7:0] WP_SET      = 8'h80;
  localparam logic [7:0] SCR_WR_CMD  = 8'hC0;
  localparam logic [7:0] SCR_RD_CMD  = 8'hC1;
  localparam logic [7:0] PROBE_PAT   = 8'h42;

endpackage

// File: rtl/rtc_step_gen.sv
module rtc_step_gen
  import rtc_seq_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  phase_e             phase,
  input  logic [STEP_W-1:0]  step,
  input  logic [IDX_W-1:0]   idx,
  input  logic [7:0]         data,
  output bus_op_e            op,
  output logic [7:0]         obyte,
  output logic               last
);
  localparam int PAD_W = 7;

  logic [PAD_W-1:0] idx_ext;
  logic [7:0]       wr_cmd, rd_cmd;

  assign idx_ext = PAD_W'(idx);
  assign wr_cmd  = 8'h80 | {idx_ext, 1'b0};
  assign rd_cmd  = 8'h81 | {idx_ext, 1'b0};

  always_comb begin
    op    = OP_STOP;
    obyte = 8'h00;
    last  = 1'b0;
    unique case (phase)
      PH_RD: begin
        case (step)
          4'd0: op = OP_START;
          4'd1: begin op = OP_WRITE; obyte = rd_cmd; end
          4'd2: op = OP_READ;
          default: begin op = OP_STOP; last = 1'b1; end
        endcase
      end
      PH_WR: begin
        case (step)
          4'd0, 4'd4, 4'd8: op = OP_START;
          4'd1, 4'd9:       begin op = OP_WRITE; obyte = CTRL_WR_CMD; end
          4'd2:             begin op = OP_WRITE; obyte = WP_CLEAR; end
          4'd5:             begin op = OP_WRITE; obyte = wr_cmd; end
          4'd6:             begin op = OP_WRITE; obyte = data; end
          4'd10:            begin op = OP_WRITE; obyte = WP_SET; end
          4'd11:            begin op = OP_STOP; last = 1'b1; end
          default:          op = OP_STOP;
        endcase
      end
      PH_PROBE: begin
        case (step)
          4'd0, 4'd4, 4'd7: op = OP_START;
          4'd1:             begin op = OP_WRITE; obyte = CTRL_WR_CMD; end
          4'd2:             begin op = OP_WRITE; obyte = WP_CLEAR; end
          4'd5:             begin op = OP_WRITE; obyte = SCR_WR_CMD; end
          4'd6:             begin op = OP_WRITE; obyte = PROBE_PAT; end
          4'd8:             begin op = OP_WRITE; obyte = SCR_RD_CMD; end
          4'd9:             op = OP_READ;
          4'd10:            begin op = OP_STOP; last = 1'b1; end
          default:          op = OP_STOP;
        endcase
      end
      PH_PROBE_WP: begin
        case (step)
          4'd0: op = OP_START;
          4'd1: begin op = OP_WRITE; obyte = CTRL_WR_CMD; end
          4'd2: begin op = OP_WRITE; obyte = WP_SET; end
          default: begin op = OP_STOP; last = 1'b1; end
        endcase
      end
      default: begin
        op   = OP_STOP;
        last = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/rtc_req_filter.sv
module rtc_req_filter #(
  parameter int IDX_W       = 5,
  parameter bit READ_ONLY   = 1'b0,
  parameter int TRICKLE_IDX = 8
) (
  input  logic             present,
  input  logic             is_write,
  input  logic [IDX_W-1:0] idx,
  output logic             refuse
);
  logic ro_block;

  generate
    if (READ_ONLY) begin : g_ro
      assign ro_block = is_write && (idx != IDX_W'(TRICKLE_IDX));
    end else begin : g_rw
      assign ro_block = 1'b0;
    end
  endgenerate

  assign refuse = !present || ro_block;
endmodule

// File: rtl/rtc_wp_seq.sv
module rtc_wp_seq
  import rtc_seq_pkg::*;
#(
  parameter int         IDX_W       = 5,
  parameter bit         READ_ONLY   = 1'b0,
  parameter int         TRICKLE_IDX = 8,
  parameter int         SEC_IDX     = 0,
  parameter logic [7:0] TRICKLE_TAG = 8'hA0,
  parameter logic [7:0] CHARGE      = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [7:0]       req_wdata,
  output logic             busy,
  output logic             resp_done,
  output logic             resp_err,
  output logic [7:0]       resp_rdata,
  output logic             dev_present,
  output logic             txn_valid,
  output logic [1:0]       txn_op,
  output logic [7:0]       txn_byte,
  input  logic             txn_ack,
  input  logic [7:0]       txn_rdata
);
  localparam logic [7:0] TRICKLE_VAL = (TRICKLE_TAG & 8'hF0) | {4'h0, CHARGE[3:0]};
  localparam logic [7:0] HALT_CLR    = 8'h7F;

  phase_e             phase;
  init_e              istage;
  logic [STEP_W-1:0]  step;
  logic [IDX_W-1:0]   cur_idx;
  logic [7:0]         cur_data;
  logic [7:0]         rbyte;

  bus_op_e            sg_op;
  logic [7:0]         sg_byte;
  logic               sg_last;
  logic               refuse;

  rtc_step_gen #(.IDX_W(IDX_W)) u_steps (
    .phase (phase),
    .step  (step),
    .idx   (cur_idx),
    .data  (cur_data),
    .op    (sg_op),
    .obyte (sg_byte),
    .last  (sg_last)
  );

  rtc_req_filter #(
    .IDX_W       (IDX_W),
    .READ_ONLY   (READ_ONLY),
    .TRICKLE_IDX (TRICKLE_IDX)
  ) u_filter (
    .present  (dev_present),
    .is_write (req_write),
    .idx      (req_idx),
    .refuse   (refuse)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase       <= PH_PROBE;
      istage      <= IN_NONE;
      step        <= '0;
      cur_idx     <= '0;
      cur_data    <= '0;
      rbyte       <= '0;
      busy        <= 1'b1;
      dev_present <= 1'b0;
      resp_done   <= 1'b0;
      resp_err    <= 1'b0;
      resp_rdata  <= '0;
      txn_valid   <= 1'b0;
      txn_op      <= OP_START;
      txn_byte    <= '0;
    end else begin
      resp_done <= 1'b0;
      resp_err  <= 1'b0;
      if (phase == PH_IDLE) begin
        if (req_valid) begin
          if (refuse) begin
            resp_done <= 1'b1;
            resp_err  <= 1'b1;
          end else begin
            phase    <= req_write ? PH_WR : PH_RD;
            cur_idx  <= req_idx;
            cur_data <= req_wdata;
            step     <= '0;
            busy     <= 1'b1;
          end
        end
      end else if (!txn_valid) begin
        txn_valid <= 1'b1;
        txn_op    <= sg_op;
        txn_byte  <= sg_byte;
      end else if (txn_ack) begin
        txn_valid <= 1'b0;
        if (txn_op == OP_READ) rbyte <= txn_rdata;
        if (!sg_last) begin
          step <= step + 1'b1;
        end else begin
          step <= '0;
          case (phase)
            PH_PROBE: begin
              if (rbyte == PROBE_PAT) begin
                phase <= PH_PROBE_WP;
              end else begin
                phase <= PH_IDLE;
                busy  <= 1'b0;
              end
            end
            PH_PROBE_WP: begin
              dev_present <= 1'b1;
              phase       <= PH_WR;
              cur_idx     <= IDX_W'(TRICKLE_IDX);
              cur_data    <= TRICKLE_VAL;
              istage      <= IN_TRICKLE;
            end
            PH_RD: begin
              if (istage == IN_SEC_RD) begin
                phase    <= PH_WR;
                cur_data <= rbyte & HALT_CLR;
                istage   <= IN_SEC_WR;
              end else begin
                phase      <= PH_IDLE;
                busy       <= 1'b0;
                resp_done  <= 1'b1;
                resp_rdata <= rbyte;
              end
            end
            default: begin
              case (istage)
                IN_TRICKLE: begin
                  phase   <= PH_RD;
                  cur_idx <= IDX_W'(SEC_IDX);
                  istage  <= IN_SEC_RD;
                end
                IN_SEC_WR: begin
                  phase  <= PH_IDLE;
                  busy   <= 1'b0;
                  istage <= IN_NONE;
                end
                default: begin
                  phase     <= PH_IDLE;
                  busy      <= 1'b0;
                  resp_done <= 1'b1;
                end
              endcase
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/rtc_wp_seq_chk.sv
module rtc_wp_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       busy,
  input logic       resp_done,
  input logic       resp_err,
  input logic       dev_present,
  input logic       txn_valid,
  input logic [1:0] txn_op,
  input logic [7:0] txn_byte,
  input logic       txn_ack
);
  // R10: a pending operation is held unchanged until acknowledged
  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (txn_valid && !txn_ack) |=> (txn_valid && $stable(txn_op) && $stable(txn_byte)));

  // R10: no bus activity outside a sequence
  p_bus_only_busy_r10: assert property (@(posedge clk) disable iff (rst)
    txn_valid |-> busy);

  // R11: completion is a single-cycle pulse
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    resp_done |=> !resp_done);

  // R11: completion never overlaps a running sequence
  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    resp_done |-> !busy);

  // R11: error flag only accompanies a completion
  p_err_with_done_r11: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_done);

  // R4: presence is sticky once set
  p_present_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    dev_present |=> dev_present);
endmodule

bind rtc_wp_seq rtc_wp_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .busy        (busy),
  .resp_done   (resp_done),
  .resp_err    (resp_err),
  .dev_present (dev_present),
  .txn_valid   (txn_valid),
  .txn_op      (txn_op),
  .txn_byte    (txn_byte),
  .txn_ack     (txn_ack)
);

// File: tb/sim_dev_model.sv
module sim_dev_model #(
  parameter bit ABSENT = 1'b0
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       txn_valid,
  input  logic [1:0] txn_op,
  input  logic [7:0] txn_byte,
  output logic       txn_ack,
  output logic [7:0] txn_rdata
);
  logic [7:0] regs [0:31];
  logic [7:0] ram  [0:31];
  logic [1:0] logop   [0:255];
  logic [7:0] logbyte [0:255];
  int         logn;
  logic [7:0] cmd;
  int         bc;
  logic       cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) begin
        regs[i] <= 8'h10 + 8'(i);
        ram[i]  <= 8'h00;
      end
      regs[0]   <= 8'h85;
      regs[7]   <= 8'h80;
      regs[8]   <= 8'h00;
      logn      <= 0;
      cmd       <= 8'h00;
      bc        <= 0;
      cnt       <= 1'b0;
      txn_ack   <= 1'b0;
      txn_rdata <= 8'h00;
    end else if (txn_ack) begin
      txn_ack <= 1'b0;
      cnt     <= 1'b0;
    end else if (txn_valid) begin
      if (!cnt) begin
        cnt <= 1'b1;
      end else begin
        txn_ack        <= 1'b1;
        logop[logn]    <= txn_op;
        logbyte[logn]  <= txn_byte;
        logn           <= logn + 1;
        case (txn_op)
          2'd0: bc <= 0;
          2'd1: begin
            bc <= bc + 1;
            if (bc == 0) cmd <= txn_byte;
            else if (cmd[7] && !cmd[0]) begin
              if (cmd[6]) begin
                if (!regs[7][7]) ram[cmd[5:1]] <= txn_byte;
              end else if (cmd[5:1] == 5'd7) begin
                regs[7] <= txn_byte;
              end else if (!regs[7][7]) begin
                regs[cmd[5:1]] <= txn_byte;
              end
            end
          end
          2'd2: txn_rdata <= ABSENT ? 8'hFF :
                             (cmd[6] ? ram[cmd[5:1]] : regs[cmd[5:1]]);
          default: bc <= 0;
        endcase
      end
    end
  end
endmodule

// File: tb/sim_rtc_wp_seq.sv
module sim_rtc_wp_seq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic       rq_v [3];
  logic       rq_w [3];
  logic [4:0] rq_i [3];
  logic [7:0] rq_d [3];
  logic       bsy [3], dn [3], er [3], pr [3], tv [3], ta [3];
  logic [7:0] rd [3], tb_ [3], tr [3];
  logic [1:0] to [3];

  int checks = 0;
  int fails  = 0;
  bit over   = 0;

  rtc_wp_seq #(.CHARGE(8'hF5)) u0 (
    .clk(clk), .rst(rst), .req_valid(rq_v[0]), .req_write(rq_w[0]), .req_idx(rq_i[0]),
    .req_wdata(rq_d[0]), .busy(bsy[0]), .resp_done(dn[0]), .resp_err(er[0]),
    .resp_rdata(rd[0]), .dev_present(pr[0]), .txn_valid(tv[0]), .txn_op(to[0]),
    .txn_byte(tb_[0]), .txn_ack(ta[0]), .txn_rdata(tr[0]));
  sim_dev_model u_m0 (.clk(clk), .rst(rst), .txn_valid(tv[0]), .txn_op(to[0]),
    .txn_byte(tb_[0]), .txn_ack(ta[0]), .txn_rdata(tr[0]));

  rtc_wp_seq #(.READ_ONLY(1'b1)) u1 (
    .clk(clk), .rst(rst), .req_valid(rq_v[1]), .req_write(rq_w[1]), .req_idx(rq_i[1]),
    .req_wdata(rq_d[1]), .busy(bsy[1]), .resp_done(dn[1]), .resp_err(er[1]),
    .resp_rdata(rd[1]), .dev_present(pr[1]), .txn_valid(tv[1]), .txn_op(to[1]),
    .txn_byte(tb_[1]), .txn_ack(ta[1]), .txn_rdata(tr[1]));
  sim_dev_model u_m1 (.clk(clk), .rst(rst), .txn_valid(tv[1]), .txn_op(to[1]),
    .txn_byte(tb_[1]), .txn_ack(ta[1]), .txn_rdata(tr[1]));

  rtc_wp_seq u2 (
    .clk(clk), .rst(rst), .req_valid(rq_v[2]), .req_write(rq_w[2]), .req_idx(rq_i[2]),
    .req_wdata(rq_d[2]), .busy(bsy[2]), .resp_done(dn[2]), .resp_err(er[2]),
    .resp_rdata(rd[2]), .dev_present(pr[2]), .txn_valid(tv[2]), .txn_op(to[2]),
    .txn_byte(tb_[2]), .txn_ack(ta[2]), .txn_rdata(tr[2]));
  sim_dev_model #(.ABSENT(1'b1)) u_m2 (.clk(clk), .rst(rst), .txn_valid(tv[2]),
    .txn_op(to[2]), .txn_byte(tb_[2]), .txn_ack(ta[2]), .txn_rdata(tr[2]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int log_n(input int w);
    case (w)
      0: return u_m0.logn;
      1: return u_m1.logn;
      default: return u_m2.logn;
    endcase
  endfunction

  function automatic logic [9:0] log_at(input int w, input int k);
    case (w)
      0: return {u_m0.logop[k], u_m0.logbyte[k]};
      1: return {u_m1.logop[k], u_m1.logbyte[k]};
      default: return {u_m2.logop[k], u_m2.logbyte[k]};
    endcase
  endfunction

  // compare a logged operation; bytes only matter for sends
  task automatic chk_op(input int w, input int k, input logic [1:0] op, input logic [7:0] b,
                        input string req);
    logic [9:0] e;
    e = log_at(w, k);
    chk(e[9:8] == op && (op != 2'd1 || e[7:0] == b), req, int'(e), int'({op, b}));
  endtask

  task automatic chk_wr_seq(input int w, input int base, input logic [4:0] idx,
                            input logic [7:0] d, input string req);
    chk_op(w, base+0, 2'd0, 8'h00, req);  chk_op(w, base+1, 2'd1, 8'h8E, req);
    chk_op(w, base+2, 2'd1, 8'h00, req);  chk_op(w, base+3, 2'd3, 8'h00, req);
    chk_op(w, base+4, 2'd0, 8'h00, req);  chk_op(w, base+5, 2'd1, 8'h80 | {2'b00, idx, 1'b0}, req);
    chk_op(w, base+6, 2'd1, d, req);      chk_op(w, base+7, 2'd3, 8'h00, req);
    chk_op(w, base+8, 2'd0, 8'h00, req);  chk_op(w, base+9, 2'd1, 8'h8E, req);
    chk_op(w, base+10, 2'd1, 8'h80, req); chk_op(w, base+11, 2'd3, 8'h00, req);
  endtask

  task automatic chk_rd_seq(input int w, input int base, input logic [4:0] idx, input string req);
    chk_op(w, base+0, 2'd0, 8'h00, req);
    chk_op(w, base+1, 2'd1, 8'h81 | {2'b00, idx, 1'b0}, req);
    chk_op(w, base+2, 2'd2, 8'h00, req);
    chk_op(w, base+3, 2'd3, 8'h00, req);
  endtask

  task automatic do_req(input int w, input bit wr, input logic [4:0] idx, input logic [7:0] d,
                        output logic [7:0] rdat, output bit err, output bit got);
    @(negedge clk);
    rq_v[w] = 1'b1; rq_w[w] = wr; rq_i[w] = idx; rq_d[w] = d;
    @(negedge clk);
    rq_v[w] = 1'b0;
    got = 0; rdat = 8'h00; err = 0;
    for (int c = 0; c < 500 && !got; c++) begin
      if (dn[w]) begin
        got = 1; rdat = rd[w]; err = er[w];
        @(negedge clk);
        chk(!dn[w], "R11 done width", int'(dn[w]), 0);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic wait_idle(input int w);
    for (int c = 0; c < 3000 && bsy[w]; c++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bsy[0] == 1'b1, "R8 busy after reset", int'(bsy[0]), 1);
    chk(pr[0] == 1'b0, "R4 present low at reset", int'(pr[0]), 0);
    chk(dn[0] == 1'b0, "R11 no done at reset", int'(dn[0]), 0);
  endtask

  task automatic t_init;
    wait_idle(0);
    chk(bsy[0] == 1'b0, "R8 busy falls after init", int'(bsy[0]), 0);
    chk(pr[0] == 1'b1, "R4 present after probe", int'(pr[0]), 1);
    chk(log_n(0) == 43, "R7 init op count", log_n(0), 43);
    chk_op(0, 0, 2'd0, 8'h00, "R4"); chk_op(0, 1, 2'd1, 8'h8E, "R4");
    chk_op(0, 2, 2'd1, 8'h00, "R4"); chk_op(0, 3, 2'd3, 8'h00, "R4");
    chk_op(0, 4, 2'd0, 8'h00, "R4"); chk_op(0, 5, 2'd1, 8'hC0, "R4");
    chk_op(0, 6, 2'd1, 8'h42, "R4"); chk_op(0, 7, 2'd0, 8'h00, "R4");
    chk_op(0, 8, 2'd1, 8'hC1, "R4"); chk_op(0, 9, 2'd2, 8'h00, "R4");
    chk_op(0, 10, 2'd3, 8'h00, "R4");
    chk_op(0, 11, 2'd0, 8'h00, "R4 wp restore"); chk_op(0, 12, 2'd1, 8'h8E, "R4 wp restore");
    chk_op(0, 13, 2'd1, 8'h80, "R4 wp restore"); chk_op(0, 14, 2'd3, 8'h00, "R4 wp restore");
    chk_wr_seq(0, 15, 5'd8, 8'hA5, "R6 trickle write");
    chk(u_m0.regs[8] == 8'hA5, "R6 trickle value", int'(u_m0.regs[8]), 'hA5);
    chk_rd_seq(0, 27, 5'd0, "R7 seconds read");
    chk_wr_seq(0, 31, 5'd0, 8'h05, "R7 seconds write");
    chk(u_m0.regs[0] == 8'h05, "R7 halt cleared", int'(u_m0.regs[0]), 'h05);
    chk(u_m0.regs[7] == 8'h80, "R2 protection restored", int'(u_m0.regs[7]), 'h80);
  endtask

  task automatic t_read;
    logic [7:0] r; bit e, g; int b;
    b = log_n(0);
    do_req(0, 1'b0, 5'd3, 8'h00, r, e, g);
    chk(g && !e, "R1 read completes", int'({g, e}), 2);
    chk(r == 8'h13, "R1 read data", int'(r), 'h13);
    chk(log_n(0) == b + 4, "R1 op count", log_n(0) - b, 4);
    chk_rd_seq(0, b, 5'd3, "R1 read sequence");
  endtask

  task automatic t_write;
    logic [7:0] r; bit e, g; int b;
    b = log_n(0);
    do_req(0, 1'b1, 5'd5, 8'h3C, r, e, g);
    chk(g && !e, "R2 write completes", int'({g, e}), 2);
    chk(log_n(0) == b + 12, "R2 op count", log_n(0) - b, 12);
    chk_wr_seq(0, b, 5'd5, 8'h3C, "R2 write sequence");
    chk(u_m0.regs[5] == 8'h3C && u_m0.regs[7] == 8'h80, "R2 device state",
        int'({u_m0.regs[5], u_m0.regs[7]}), 'h3C80);
    do_req(0, 1'b0, 5'd5, 8'h00, r, e, g);
    chk(r == 8'h3C, "R2 read back", int'(r), 'h3C);
  endtask

  task automatic t_busy_ignore;
    int b, dones;
    b = log_n(0);
    dones = 0;
    @(negedge clk);
    rq_v[0] = 1'b1; rq_w[0] = 1'b0; rq_i[0] = 5'd3;
    @(negedge clk);
    rq_v[0] = 1'b0;
    @(negedge clk);
    chk(bsy[0] == 1'b1, "R8 busy during request", int'(bsy[0]), 1);
    rq_v[0] = 1'b1; rq_w[0] = 1'b1; rq_i[0] = 5'd6; rq_d[0] = 8'hEE;
    @(negedge clk);
    rq_v[0] = 1'b0;
    for (int c = 0; c < 300; c++) begin
      if (dn[0]) dones++;
      @(negedge clk);
    end
    chk(dones == 1, "R8 ignored request count", dones, 1);
    chk(log_n(0) == b + 4, "R8 ignored request ops", log_n(0) - b, 4);
    chk(u_m0.regs[6] == 8'h16, "R8 ignored write effect", int'(u_m0.regs[6]), 'h16);
  endtask

  task automatic t_readonly;
    logic [7:0] r; bit e, g; int b;
    wait_idle(1);
    b = log_n(1);
    do_req(1, 1'b1, 5'd5, 8'h77, r, e, g);
    chk(g && e, "R3 discarded write err", int'({g, e}), 3);
    chk(log_n(1) == b, "R3 no ops for discarded write", log_n(1) - b, 0);
    chk(u_m1.regs[5] == 8'h15, "R3 register unchanged", int'(u_m1.regs[5]), 'h15);
    do_req(1, 1'b1, 5'd8, 8'hA9, r, e, g);
    chk(g && !e, "R3 trickle write allowed", int'({g, e}), 2);
    chk(u_m1.regs[8] == 8'hA9, "R3 trickle value", int'(u_m1.regs[8]), 'hA9);
    chk(log_n(1) == b + 12, "R3 trickle op count", log_n(1) - b, 12);
  endtask

  task automatic t_absent;
    logic [7:0] r; bit e, g;
    wait_idle(2);
    chk(bsy[2] == 1'b0, "R5 busy falls on absence", int'(bsy[2]), 0);
    chk(pr[2] == 1'b0, "R5 present stays low", int'(pr[2]), 0);
    chk(log_n(2) == 11, "R5 no ops after probe", log_n(2), 11);
    do_req(2, 1'b0, 5'd1, 8'h00, r, e, g);
    chk(g && e, "R9 refused when absent", int'({g, e}), 3);
    chk(log_n(2) == 11, "R9 no ops when absent", log_n(2), 11);
  endtask

  initial begin
    for (int k = 0; k < 3; k++) begin
      rq_v[k] = 1'b0; rq_w[k] = 1'b0; rq_i[k] = '0; rq_d[k] = '0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_init();
    t_read();
    t_write();
    t_busy_ignore();
    t_readonly();
    t_absent();
    if (!over) begin
      over = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!over) begin
      over = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule